// File: doc/BRIEF.md
# Reset Controller with Start-up Timer

This block produces the chip-wide reset of a small microcontroller core. A reset can come from a power-up event, from an external active-low clear pin (already synchronised to the core clock), or from a watchdog time-out. Any of these sets a reset hold register and zeroes a start-up counter. The counter advances only while the clear pin reads high, and when it reaches its programmed length it releases the chip reset. The nominal start-up period is about 18 ms, expressed here as a cycle count parameter.

The block also keeps the two status flags that software reads after a reset or wake-up to learn what happened: a time-out flag and a power-down flag. A wake-up from sleep caused by the clear pin or by the watchdog is a full reset, not a resume. While the core is asleep the power-up detector is ignored.

Top module: `rstc_top`

## Requirements
- R1: While `rst` is high, the next clock edge leaves `chip_rst_o`, `to_o` and `pd_o` all at 1.
- R2: Once a reset is triggered, `chip_rst_o` stays 1 and falls after exactly `DRT_CYCLES` consecutive clock edges at which `mclr_n_i` is 1 and no other trigger is present; a 0 on `mclr_n_i` at any edge restarts that count from zero.
- R3: A 1 on `wdt_to_i` at a clock edge sets `chip_rst_o` to 1 after that edge and restarts the start-up count, whether `asleep_i` is 0 or 1.
- R4: `por_i` at an edge where `asleep_i` is 1 has no effect on `chip_rst_o`, `to_o` or `pd_o`; with `asleep_i` at 0 it acts exactly as `rst`.
- R5: `to_o` is set to 1 by a power-up event, by `clrwdt_i` or by `sleep_enter_i`, and is cleared to 0 by `wdt_to_i`; when the clear and a set arrive on the same edge, the clear wins.
- R6: `pd_o` is set to 1 by a power-up event or by `clrwdt_i`, and cleared to 0 by `sleep_enter_i`; when both arrive on the same edge, the clear wins.
- R7: A reset caused only by `mclr_n_i` low leaves `to_o` and `pd_o` unchanged.
- R8: A power-up event (`rst`, or `por_i` while awake) overrides every other input on the same edge: reset is set and both flags become 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| por_i | input | 1 | Power-on detector pulse, ignored while asleep |
| mclr_n_i | input | 1 | Synchronised external clear pin, active low |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| sleep_enter_i | input | 1 | Strobe: core executes its sleep instruction |
| clrwdt_i | input | 1 | Strobe: core clears the watchdog |
| asleep_i | input | 1 | Core is in sleep mode |
| chip_rst_o | output | 1 | Registered chip reset, active high |
| to_o | output | 1 | Time-out status flag |
| pd_o | output | 1 | Power-down status flag |

## Verification
The hardest situation to reach is a clear-pin glitch in the middle of a start-up count, combined with a watchdog wake-up from sleep while a power-on pulse is also presented and must be ignored. The stimulus releases the clear pin, drops it again a few cycles before the count would finish, and later enters sleep, pulses the power-on input (expecting no change) and then fires the watchdog with the core still asleep. Same-edge collisions of the flag set and clear strobes are driven explicitly to pin down the priorities.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  // Decoded events for one clock edge
  typedef struct packed {
    logic power;   // power-up: rst, or por while awake
    logic trig;    // any cause that (re)arms the reset hold
    logic wdt;     // watchdog time-out
    logic clrwdt;  // watchdog clear strobe
    logic sleep;   // sleep entry strobe
    logic pin_hi;  // clear pin reads released
  } rstc_evt_t;

endpackage

// File: rtl/rstc_evt_decode.sv
module rstc_evt_decode
  import rstc_pkg::*;
(
  input  logic      rst,
  input  logic      por_i,
  input  logic      mclr_n_i,
  input  logic      wdt_to_i,
  input  logic      sleep_enter_i,
  input  logic      clrwdt_i,
  input  logic      asleep_i,
  output rstc_evt_t ev_o
);

  logic power_w;

  // Power detector is masked while the core sleeps
  assign power_w = rst | (por_i & ~asleep_i);

  always_comb begin
    ev_o        = '0;
    ev_o.power  = power_w;
    ev_o.trig   = power_w | ~mclr_n_i | wdt_to_i;
    ev_o.wdt    = wdt_to_i;
    ev_o.clrwdt = clrwdt_i;
    ev_o.sleep  = sleep_enter_i;
    ev_o.pin_hi = mclr_n_i;
  end

endmodule

// File: rtl/rstc_drt.sv
module rstc_drt
  import rstc_pkg::*;
#(
  parameter int DRT_CYCLES = 360000
) (
  input  logic      clk,
  input  logic      rst,
  input  rstc_evt_t ev_i,
  output logic      hold_o
);

  localparam int CNT_W = (DRT_CYCLES > 2) ? $clog2(DRT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DRT_CYCLES - 1);

  logic             hold_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (ev_i.trig) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q) begin
      if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;

  AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (rst)
    ev_i.trig |=> hold_q); // R3

  AST_RELEASE_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !ev_i.pin_hi) |=> hold_q); // R2

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> (cnt_q <= LAST)); // R2

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hold_q |-> (cnt_q == '0)); // R2

endmodule

// File: rtl/rstc_flags.sv
module rstc_flags
  import rstc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rstc_evt_t ev_i,
  output logic      to_o,
  output logic      pd_o
);

  logic to_q;
  logic pd_q;

  always_ff @(posedge clk) begin
    if (ev_i.power) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else begin
      if (ev_i.wdt)
        to_q <= 1'b0;
      else if (ev_i.clrwdt || ev_i.sleep)
        to_q <= 1'b1;

      if (ev_i.sleep)
        pd_q <= 1'b0;
      else if (ev_i.clrwdt)
        pd_q <= 1'b1;
    end
  end

  assign to_o = to_q;
  assign pd_o = pd_q;

  AST_POWER_SETS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ev_i.power |=> (to_q && pd_q)); // R8

  AST_WDT_CLEARS_TO: assert property (@(posedge clk) disable iff (rst)
    (ev_i.wdt && !ev_i.power) |=> !to_q); // R5

  AST_SLEEP_CLEARS_PD: assert property (@(posedge clk) disable iff (rst)
    (ev_i.sleep && !ev_i.power) |=> !pd_q); // R6

  AST_PIN_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!ev_i.power && !ev_i.wdt && !ev_i.clrwdt && !ev_i.sleep)
      |=> ($stable(to_q) && $stable(pd_q))); // R7

endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int DRT_CYCLES = 360000
) (
  input  logic clk,
  input  logic rst,
  input  logic por_i,
  input  logic mclr_n_i,
  input  logic wdt_to_i,
  input  logic sleep_enter_i,
  input  logic clrwdt_i,
  input  logic asleep_i,
  output logic chip_rst_o,
  output logic to_o,
  output logic pd_o
);

  rstc_evt_t ev;

  rstc_evt_decode u_dec (
    .rst           (rst),
    .por_i         (por_i),
    .mclr_n_i      (mclr_n_i),
    .wdt_to_i      (wdt_to_i),
    .sleep_enter_i (sleep_enter_i),
    .clrwdt_i      (clrwdt_i),
    .asleep_i      (asleep_i),
    .ev_o          (ev)
  );

  rstc_drt #(.DRT_CYCLES(DRT_CYCLES)) u_drt (
    .clk    (clk),
    .rst    (rst),
    .ev_i   (ev),
    .hold_o (chip_rst_o)
  );

  rstc_flags u_flags (
    .clk  (clk),
    .rst  (rst),
    .ev_i (ev),
    .to_o (to_o),
    .pd_o (pd_o)
  );

  AST_SLEEP_POR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (asleep_i && por_i && mclr_n_i && !wdt_to_i && !clrwdt_i && !sleep_enter_i)
      |=> ($stable(to_o) && $stable(pd_o))); // R4

endmodule

// File: tb/tb_rstc_top.sv
module tb_rstc_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst, por, mclr_n, wdt, slp, clr, asleep;
  logic chip_rst, to_f, pd_f;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference model state
  int m_hold = 1, m_cnt = 0, m_to = 1, m_pd = 1;
  bit checking = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstc_top #(.DRT_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .por_i(por), .mclr_n_i(mclr_n), .wdt_to_i(wdt),
    .sleep_enter_i(slp), .clrwdt_i(clr), .asleep_i(asleep),
    .chip_rst_o(chip_rst), .to_o(to_f), .pd_o(pd_f)
  );

  task automatic idle_inputs();
    rst = 0; por = 0; mclr_n = 1; wdt = 0; slp = 0; clr = 0;
  endtask

  // One clock: inputs already driven; advance model, compare after edge
  task automatic step();
    bit pw, trig;
    @(posedge clk);
    pw   = rst || (por && !asleep);
    trig = pw || !mclr_n || wdt;
    if (trig) begin m_hold = 1; m_cnt = 0; end
    else if (m_hold == 1) begin
      m_cnt++;
      if (m_cnt == N) begin m_hold = 0; m_cnt = 0; end
    end
    if (pw) begin m_to = 1; m_pd = 1; end
    else begin
      if (wdt) m_to = 0; else if (clr || slp) m_to = 1;
      if (slp) m_pd = 0; else if (clr) m_pd = 1;
    end
    #1;
    if (checking) begin
      tests++;
      if (chip_rst !== m_hold[0] || to_f !== m_to[0] || pd_f !== m_pd[0]) begin
        fails++;
        $display("FAIL %s: rst/to/pd actual %b%b%b expected %0d%0d%0d",
                 cur_req, chip_rst, to_f, pd_f, m_hold, m_to, m_pd);
      end
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    asleep = 0;
    rst = 1;
    @(negedge clk);
    checking = 1'b1;
    // R1: reset state
    cur_req = "R1"; rst = 1; step(); rst = 1; step();
    // R2: release after N high cycles
    cur_req = "R2"; run(N + 3);
    // R7: clear pin pulse leaves flags alone; then restart timing
    cur_req = "R7"; clr = 1; step(); slp = 1; step();
    mclr_n = 0; step(); mclr_n = 0; step(); mclr_n = 0; step();
    cur_req = "R2"; run(N - 3);
    mclr_n = 0; step();               // glitch mid-count restarts
    run(N + 2);
    // R5 / R6: strobes
    cur_req = "R5"; wdt = 1; step(); run(2); clr = 1; step();
    cur_req = "R6"; slp = 1; step(); clr = 1; step();
    // R5 / R6 same-edge priorities
    cur_req = "R5"; wdt = 1; clr = 1; slp = 1; step();
    cur_req = "R6"; clr = 1; slp = 1; step();
    run(N + 1);
    // R4: por ignored while asleep
    cur_req = "R4"; asleep = 1; slp = 1; step();
    por = 1; step(); por = 1; step(); run(2);
    // R3: watchdog wake-up from sleep is a full reset
    cur_req = "R3"; wdt = 1; step(); asleep = 0; run(N + 2);
    // R3 awake watchdog restarts a running count
    wdt = 1; step(); run(N - 2); wdt = 1; step(); run(N + 1);
    // R8: power-up overrides everything; R4 por awake
    cur_req = "R8"; slp = 1; step();
    por = 1; wdt = 1; slp = 1; mclr_n = 0; step();
    run(N + 1);
    cur_req = "R4"; por = 1; step(); run(N + 1);
    cur_req = "R1"; rst = 1; wdt = 1; slp = 1; step(); run(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule